// File: doc/BRIEF.md
# Next-Address Resolver

This block picks the address of the following instruction for a 32-bit core whose instructions are all one word long and word-aligned. Each cycle it takes the current fetch address, two register values, a signed 16-bit word offset, a 26-bit jump index, a register-held target and a decoded control class. From these it produces the next fetch address, a flag that shows whether control flow left the straight-line path, and a request to write a return address together with that address.

It covers two-register equality branches, sign tests of one register against zero, the linking forms of those sign tests, and three jump styles: direct, direct with link, and indirect through a register. A direct jump stays inside the 256 MB region of the current address. The outputs are registered by default, so results appear one clock after their inputs. A parameter can instead select a purely combinational path.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` is `RESET_PC` (default 0) and `redirect`, `link_we` and `link_val` are 0.
- R2: Class 0 (straight-line) yields `next_pc = cur_pc + 4`, `redirect = 0` and `link_we = 0`.
- R3: Class 1 (equal) redirects when `opnd_a == opnd_b`. Class 2 (not equal) redirects when they differ.
- R4: Sign tests apply to `opnd_a` as a two's-complement value. Class 3 tests <= 0, class 4 tests > 0, class 5 tests < 0 and class 6 tests >= 0.
- R5: A taken branch goes to `cur_pc + 4 + (sign-extended br_offset << 2)`. This holds for backward offsets and for the extreme offsets 0x7FFF and 0x8000. An untaken branch goes to `cur_pc + 4`.
- R6: Class 9 (direct jump) always redirects, to `{cur_pc[31:28], jmp_index, 2'b00}`. The region bits come from the current address, not from `cur_pc + 4`.
- R7: The linking classes are 7 (link if < 0), 8 (link if >= 0) and 10 (direct jump with link). They assert `link_we` with `link_val = cur_pc + 4` whether or not the branch is taken. No other class asserts `link_we`.
- R8: Class 11 (indirect jump) always redirects to `reg_target` and does not link.
- R9: Classes 12 to 15 act like class 0: `next_pc = cur_pc + 4`, no redirect and no link.
- R10: With the default `REG_OUT = 1`, every output reflects the inputs sampled at the previous rising clock edge. A change of inputs does not appear before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the current instruction |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| br_offset | input | 16 | Signed branch offset in words |
| jmp_index | input | 26 | Word index for direct jumps |
| reg_target | input | 32 | Target for the indirect jump |
| ctrl_class | input | 4 | Decoded control-flow class |
| next_pc | output | 32 | Next fetch address |
| redirect | output | 1 | Control flow leaves the straight-line path |
| link_we | output | 1 | Request to write the return address |
| link_val | output | 32 | Return address (`cur_pc + 4` when linking, else 0) |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. `next_pc`, `redirect` and the link pair all leave the same output register stage. The bench changes inputs on a falling edge and samples on the next falling edge, which puts each check half a period away from the edge that loads it. One scenario changes the inputs and then looks again before the next rising edge, to confirm that the previous result is still held. The reset check is made while reset is held, before any inputs have been applied.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CL_SEQ      = 4'd0,
      CL_EQ       = 4'd1,
      CL_NE       = 4'd2,
      CL_LEZ      = 4'd3,
      CL_GTZ      = 4'd4,
      CL_LTZ      = 4'd5,
      CL_GEZ      = 4'd6,
      CL_LTZ_LINK = 4'd7,
      CL_GEZ_LINK = 4'd8,
      CL_JMP      = 4'd9,
      CL_JMP_LINK = 4'd10,
      CL_JREG     = 4'd11
   } ctrl_class_e;

   localparam logic [CLS_W-1:0] CL_LAST = 4'd11;
endpackage

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN        = 32,
   parameter int OFF_W       = 16,
   parameter int IDX_W       = 26,
   parameter int INSN_BYTES  = 4,
   parameter bit REGION_SEQ  = 1'b0
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   input  logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  br_pc,
   output logic [XLEN-1:0]  jmp_pc
);
   localparam int SH    = $clog2(INSN_BYTES);
   localparam int REG_W = XLEN - IDX_W - SH;
   localparam int EXT_W = XLEN - OFF_W - SH;

   if (INSN_BYTES < 2 || (1 << SH) != INSN_BYTES) begin : g_bad_bytes
      $error("INSN_BYTES must be a power of two of at least 2");
   end
   if (REG_W < 1) begin : g_bad_region
      $error("IDX_W leaves no region bits");
   end
   if (EXT_W < 1) begin : g_bad_off
      $error("OFF_W too wide for XLEN");
   end

   logic [XLEN-1:0] off_ext;
   logic [XLEN-1:0] region_src;

   assign seq_pc  = pc + XLEN'(INSN_BYTES);
   assign off_ext = {{EXT_W{off[OFF_W-1]}}, off, {SH{1'b0}}};
   assign br_pc   = seq_pc + off_ext;

   if (REGION_SEQ) begin : g_region_seq
      assign region_src = seq_pc;
   end else begin : g_region_cur
      assign region_src = pc;
   end

   assign jmp_pc = {region_src[XLEN-1 -: REG_W], idx, {SH{1'b0}}};
endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int XLEN = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [npc_pkg::CLS_W-1:0]  cls,
   input  logic [XLEN-1:0]            a,
   input  logic [XLEN-1:0]            b,
   output logic                       cond
);
   import npc_pkg::*;

   logic neg, zero;

   assign neg  = a[XLEN-1];
   assign zero = (a == '0);

   always_comb begin
      case (cls)
         CL_EQ:                    cond = (a == b);
         CL_NE:                    cond = (a != b);
         CL_LEZ:                   cond = neg | zero;
         CL_GTZ:                   cond = ~neg & ~zero;
         CL_LTZ, CL_LTZ_LINK:      cond = neg;
         CL_GEZ, CL_GEZ_LINK:      cond = ~neg;
         default:                  cond = 1'b0;
      endcase
   end

   // R3: unequal operands never satisfy the equality test
   p_eq_false_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CL_EQ && a != b) |-> !cond);
   // R4: a negative operand never satisfies the greater-than-zero test
   p_gtz_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CL_GTZ && $signed(a) < 0) |-> !cond);
endmodule

// File: rtl/npc_select.sv
module npc_select #(
   parameter int XLEN = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [npc_pkg::CLS_W-1:0]  cls,
   input  logic                       cond,
   input  logic [XLEN-1:0]            seq_pc,
   input  logic [XLEN-1:0]            br_pc,
   input  logic [XLEN-1:0]            jmp_pc,
   input  logic [XLEN-1:0]            reg_pc,
   output logic [XLEN-1:0]            nxt_pc,
   output logic                       nxt_redirect,
   output logic                       nxt_link_we,
   output logic [XLEN-1:0]            nxt_link_val
);
   import npc_pkg::*;

   always_comb begin
      nxt_pc       = seq_pc;
      nxt_redirect = 1'b0;
      nxt_link_we  = 1'b0;
      case (cls)
         CL_EQ, CL_NE, CL_LEZ, CL_GTZ, CL_LTZ, CL_GEZ: begin
            nxt_redirect = cond;
            nxt_pc       = cond ? br_pc : seq_pc;
         end
         CL_LTZ_LINK, CL_GEZ_LINK: begin
            nxt_redirect = cond;
            nxt_pc       = cond ? br_pc : seq_pc;
            nxt_link_we  = 1'b1;
         end
         CL_JMP: begin
            nxt_redirect = 1'b1;
            nxt_pc       = jmp_pc;
         end
         CL_JMP_LINK: begin
            nxt_redirect = 1'b1;
            nxt_pc       = jmp_pc;
            nxt_link_we  = 1'b1;
         end
         CL_JREG: begin
            nxt_redirect = 1'b1;
            nxt_pc       = reg_pc;
         end
         default: ;
      endcase
      nxt_link_val = nxt_link_we ? seq_pc : '0;
   end

   // R2: staying on the straight-line path means the sequential address
   p_seq_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !nxt_redirect |-> nxt_pc == seq_pc);
   // R7: the return address is always the sequential address
   p_link_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_link_we |-> nxt_link_val == seq_pc);
   // R8: the indirect jump follows the register target
   p_jreg_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CL_JREG) |-> (nxt_pc == reg_pc && nxt_redirect && !nxt_link_we));
   // R9: unknown classes neither redirect nor link
   p_unknown_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cls > CL_LAST) |-> (!nxt_redirect && !nxt_link_we));
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int          XLEN       = 32,
   parameter int          OFF_W      = 16,
   parameter int          IDX_W      = 26,
   parameter int          INSN_BYTES = 4,
   parameter bit          REGION_SEQ = 1'b0,
   parameter bit          REG_OUT    = 1'b1,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [XLEN-1:0]           cur_pc,
   input  logic [XLEN-1:0]           opnd_a,
   input  logic [XLEN-1:0]           opnd_b,
   input  logic [OFF_W-1:0]          br_offset,
   input  logic [IDX_W-1:0]          jmp_index,
   input  logic [XLEN-1:0]           reg_target,
   input  logic [npc_pkg::CLS_W-1:0] ctrl_class,
   output logic [XLEN-1:0]           next_pc,
   output logic                      redirect,
   output logic                      link_we,
   output logic [XLEN-1:0]           link_val
);
   logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
   logic            cond;
   logic [XLEN-1:0] nxt_pc, nxt_link_val;
   logic            nxt_redirect, nxt_link_we;

   npc_target #(
      .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .INSN_BYTES(INSN_BYTES), .REGION_SEQ(REGION_SEQ)
   ) i_target (
      .pc(cur_pc), .off(br_offset), .idx(jmp_index),
      .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
   );

   npc_cond #(.XLEN(XLEN)) i_cond (
      .clk(clk), .rst_n(rst_n), .cls(ctrl_class),
      .a(opnd_a), .b(opnd_b), .cond(cond)
   );

   npc_select #(.XLEN(XLEN)) i_select (
      .clk(clk), .rst_n(rst_n), .cls(ctrl_class), .cond(cond),
      .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc), .reg_pc(reg_target),
      .nxt_pc(nxt_pc), .nxt_redirect(nxt_redirect),
      .nxt_link_we(nxt_link_we), .nxt_link_val(nxt_link_val)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            next_pc  <= XLEN'(RESET_PC);
            redirect <= 1'b0;
            link_we  <= 1'b0;
            link_val <= '0;
         end else begin
            next_pc  <= nxt_pc;
            redirect <= nxt_redirect;
            link_we  <= nxt_link_we;
            link_val <= nxt_link_val;
         end
      end

      // R1: reset holds the outputs at their idle values
      p_reset_idle_r1: assert property (@(posedge clk)
         !rst_n |=> (next_pc == XLEN'(RESET_PC) && !redirect && !link_we));
   end else begin : g_comb_out
      assign next_pc  = rst_n ? nxt_pc       : XLEN'(RESET_PC);
      assign redirect = rst_n & nxt_redirect;
      assign link_we  = rst_n & nxt_link_we;
      assign link_val = rst_n ? nxt_link_val : '0;
   end

   // R5: a branch that is not taken lands on the sequential address
   p_branch_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_class >= 4'd1 && ctrl_class <= 4'd8 && !cond) |-> nxt_pc == seq_pc);
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0, opnd_a = '0, opnd_b = '0, reg_target = '0;
   logic [15:0] br_offset = '0;
   logic [25:0] jmp_index = '0;
   logic [3:0]  ctrl_class = '0;
   logic [31:0] next_pc, link_val;
   logic        redirect, link_we;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   npc_unit i_npc_unit (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .br_offset(br_offset), .jmp_index(jmp_index), .reg_target(reg_target),
      .ctrl_class(ctrl_class), .next_pc(next_pc), .redirect(redirect),
      .link_we(link_we), .link_val(link_val)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] br_dest(input logic [31:0] pc, input logic [15:0] off);
      return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
   endfunction

   task automatic apply(input logic [3:0] cls, input logic [31:0] pc, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] off, input logic [25:0] idx,
                        input logic [31:0] rt);
      @(negedge clk);
      ctrl_class = cls; cur_pc = pc; opnd_a = a; opnd_b = b;
      br_offset = off; jmp_index = idx; reg_target = rt;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [31:0] pc, input logic rd,
                             input logic lw, input logic [31:0] lv);
      chk(req, "next_pc", next_pc, pc);
      chk(req, "redirect", 32'(redirect), 32'(rd));
      chk(req, "link_we", 32'(link_we), 32'(lw));
      if (lw) chk(req, "link_val", link_val, lv);
   endtask

   task automatic t_reset;
      chk("R1", "next_pc", next_pc, 32'h0);
      chk("R1", "redirect", 32'(redirect), 32'h0);
      chk("R1", "link_we", 32'(link_we), 32'h0);
      chk("R1", "link_val", link_val, 32'h0);
   endtask

   task automatic t_seq;
      apply(4'd0, 32'h0040_0000, 32'h5, 32'h5, 16'h0010, 26'h1, 32'h1234);
      expect_out("R2", 32'h0040_0004, 1'b0, 1'b0, 32'h0);
      apply(4'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0);
      expect_out("R2", 32'h0000_0000, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_equality;
      apply(4'd1, 32'h0000_1000, 32'hABCD, 32'hABCD, 16'h0010, 26'h0, 32'h0);
      expect_out("R3", br_dest(32'h1000, 16'h0010), 1'b1, 1'b0, 32'h0);
      apply(4'd1, 32'h0000_1000, 32'hABCD, 32'hABCE, 16'h0010, 26'h0, 32'h0);
      expect_out("R3", 32'h0000_1004, 1'b0, 1'b0, 32'h0);
      apply(4'd2, 32'h0000_2000, 32'h1, 32'h8000_0001, 16'h0004, 26'h0, 32'h0);
      expect_out("R3", br_dest(32'h2000, 16'h0004), 1'b1, 1'b0, 32'h0);
      apply(4'd2, 32'h0000_2000, 32'h7, 32'h7, 16'h0004, 26'h0, 32'h0);
      expect_out("R3", 32'h0000_2004, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_zero_tests;
      logic [31:0] vals [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
      for (int c = 3; c <= 6; c++) begin
         for (int v = 0; v < 5; v++) begin
            logic t;
            case (c)
               3: t = ($signed(vals[v]) <= 0);
               4: t = ($signed(vals[v]) > 0);
               5: t = ($signed(vals[v]) < 0);
               default: t = ($signed(vals[v]) >= 0);
            endcase
            apply(4'(c), 32'h0001_0000, vals[v], 32'h0, 16'h0020, 26'h0, 32'h0);
            expect_out("R4", t ? br_dest(32'h0001_0000, 16'h0020) : 32'h0001_0004, t, 1'b0, 32'h0);
         end
      end
   endtask

   task automatic t_offsets;
      apply(4'd1, 32'h0001_0000, 32'h3, 32'h3, 16'hFFFE, 26'h0, 32'h0);
      expect_out("R5", 32'h0000_FFFC, 1'b1, 1'b0, 32'h0);
      apply(4'd1, 32'h0004_0000, 32'h3, 32'h3, 16'h7FFF, 26'h0, 32'h0);
      expect_out("R5", 32'h0006_0000, 1'b1, 1'b0, 32'h0);
      apply(4'd1, 32'h0004_0000, 32'h3, 32'h3, 16'h8000, 26'h0, 32'h0);
      expect_out("R5", 32'h0002_0004, 1'b1, 1'b0, 32'h0);
      apply(4'd2, 32'h0004_0000, 32'h3, 32'h3, 16'h8000, 26'h0, 32'h0);
      expect_out("R5", 32'h0004_0004, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_link;
      apply(4'd7, 32'h0000_3000, 32'hFFFF_FFF0, 32'h0, 16'h0008, 26'h0, 32'h0);
      expect_out("R7", br_dest(32'h3000, 16'h0008), 1'b1, 1'b1, 32'h0000_3004);
      apply(4'd7, 32'h0000_3000, 32'h0000_0010, 32'h0, 16'h0008, 26'h0, 32'h0);
      expect_out("R7", 32'h0000_3004, 1'b0, 1'b1, 32'h0000_3004);
      apply(4'd8, 32'h0000_5000, 32'h0, 32'h0, 16'hFFFF, 26'h0, 32'h0);
      expect_out("R7", 32'h0000_5000, 1'b1, 1'b1, 32'h0000_5004);
      apply(4'd8, 32'h0000_5000, 32'h8000_0000, 32'h0, 16'hFFFF, 26'h0, 32'h0);
      expect_out("R7", 32'h0000_5004, 1'b0, 1'b1, 32'h0000_5004);
   endtask

   task automatic t_jumps;
      apply(4'd9, 32'h0FFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 32'h0);
      expect_out("R6", 32'h0FFF_FFFC, 1'b1, 1'b0, 32'h0);
      apply(4'd9, 32'h1000_0000, 32'h0, 32'h0, 16'h0, 26'h000_0000, 32'h0);
      expect_out("R6", 32'h1000_0000, 1'b1, 1'b0, 32'h0);
      apply(4'd9, 32'hF000_0008, 32'h0, 32'h0, 16'h0, 26'h012_3456, 32'h0);
      expect_out("R6", 32'hF048_D158, 1'b1, 1'b0, 32'h0);
      apply(4'd10, 32'h2FFF_FFF8, 32'h0, 32'h0, 16'h0, 26'h000_0040, 32'h0);
      expect_out("R7", 32'h2000_0100, 1'b1, 1'b1, 32'h2FFF_FFFC);
      apply(4'd11, 32'h0000_4000, 32'h0, 32'h0, 16'h0, 26'h0, 32'hDEAD_BEEC);
      expect_out("R8", 32'hDEAD_BEEC, 1'b1, 1'b0, 32'h0);
   endtask

   task automatic t_unknown;
      for (int c = 12; c <= 15; c++) begin
         apply(4'(c), 32'h0000_6000, 32'h0, 32'h0, 16'h0040, 26'h0000_123, 32'h9999_0000);
         expect_out("R9", 32'h0000_6004, 1'b0, 1'b0, 32'h0);
      end
   endtask

   task automatic t_latency;
      apply(4'd0, 32'h0000_7000, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0);
      ctrl_class = 4'd11; reg_target = 32'h0000_0ABC;
      #2;
      chk("R10", "held next_pc", next_pc, 32'h0000_7004);
      chk("R10", "held redirect", 32'(redirect), 32'h0);
      @(negedge clk);
      chk("R10", "next_pc", next_pc, 32'h0000_0ABC);
      chk("R10", "redirect", 32'(redirect), 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_seq;
      t_equality;
      t_zero_tests;
      t_offsets;
      t_link;
      t_jumps;
      t_unknown;
      t_latency;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule